// File: doc/BRIEF.md
# Double-Buffered Packet Buffer Manager

This block puts received packets into a ring of fixed-size blocks in host memory. The region starts at a live base pointer and holds sixteen blocks of 2 KB. Each packet gets the next block. The payload is written from word 8 of that block onward. The first eight words are a header area: word 0 carries a completion status word, and words 1 to 7 stay untouched for the host.

One host register address loads the pointers. The first write sets the live base. Every write after that sets a shadow pointer. When the sixteenth packet of a region completes, the shadow value moves into the live base and block numbering starts again at zero. The host therefore refills the shadow once per region.

A second host address clears interrupt flags by writing ones. Three flags exist: per-packet, wrap and overrun. Memory writes leave through a valid/ready port as word addresses.

Top module: `pktbuf_mgr`

## Requirements
- R1: Payload word i (0-based beat number) of a packet placed in block k is written to word address base/4 + k*512 + 8 + i, with data equal to that beat's input word.
- R2: After reset, the first write with host_sel=0 loads the live base, the second loads the shadow, and every later one loads only the shadow.
- R3: A host pointer write never changes the live base once both pointers are loaded, so later packets of the same region stay in the same region.
- R4: When the 16th packet of a region completes, the live base takes the shadow value and the next packet goes to block 0. A pointer write in that same cycle reaches the shadow only, and the base takes the shadow value it replaces.
- R5: The status word goes to word 0 of the packet's block. Bit 31 is the sniff flag, bits 17:15 are the search code, bits 14:12 are the source port, bits 11:1 are the stored byte count, bit 0 is 1, and all other bits are 0.
- R6: The status write is the last memory write of a packet, issued only after every payload write of that packet has been accepted.
- R7: Words 1 to 7 of a block are never written.
- R8: Beats beyond the first 504 are accepted but not written. The stored byte count is min(in_len, 2016).
- R9: Flag irq_pkt sets when a status write is accepted, and irq_wrap sets on the 16th of a region. Flags are levels that stay set until a write with host_sel=1 has a 1 in the matching bit: bit 0 pkt, bit 1 wrap, bit 2 overrun.
- R10: A packet whose first beat arrives before both pointers are loaded is consumed with no memory write, and irq_ovr sets after its last beat.
- R11: While mem_valid is high and mem_ready low, mem_valid, mem_waddr and mem_wdata hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | 0: pointer register, 1: flag clear |
| host_wdata | input | 32 | Host write data |
| in_valid | input | 1 | Payload beat valid |
| in_ready | output | 1 | Payload beat accepted |
| in_data | input | 32 | Payload word |
| in_last | input | 1 | Final beat of the packet |
| in_len | input | 11 | Packet byte count, held during the packet |
| in_port | input | 3 | Source port, held during the packet |
| in_ease | input | 3 | Search code, held during the packet |
| in_sniff | input | 1 | Sniff flag, held during the packet |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory write accepted |
| mem_waddr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| irq_pkt | output | 1 | Packet-done flag |
| irq_wrap | output | 1 | Region-wrap flag |
| irq_ovr | output | 1 | Dropped-packet flag |

## Verification
The automatic shadow-to-base transfer and a host pointer write can land on the same clock edge. The bench provokes this by holding mem_ready low only for the status word of a region's 16th packet. With the status write pending, it raises the host write and releases mem_ready together.

The bench then judges the outcome from the memory addresses alone. The next region must use the shadow value that was there before the collision. The region after that must use the value written during the collision.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;
  localparam int LEN_W = 11;

  typedef enum logic [1:0] {WS_DATA, WS_STAT, WS_WAIT} wr_state_e;

  typedef struct packed {
    logic             sniff;
    logic [2:0]       ease;
    logic [2:0]       port;
    logic [LEN_W-1:0] cnt;
  } pkt_desc_t;

  function automatic logic [31:0] stat_word(pkt_desc_t d);
    return {d.sniff, 13'd0, d.ease, d.port, d.cnt, 1'b1};
  endfunction
endpackage

// File: rtl/pb_ptr_regs.sv
module pb_ptr_regs #(
  parameter int AW      = 32,
  parameter int BLK_CNT = 16,
  localparam int BLK_W  = $clog2(BLK_CNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_wr,
  input  logic [AW-1:0]    ptr_wdata,
  input  logic             adv,
  output logic [AW-1:0]    base,
  output logic [BLK_W-1:0] blk,
  output logic             armed,
  output logic             wrap
);
  localparam logic [BLK_W-1:0] LAST = BLK_W'(BLK_CNT - 1);

  logic [1:0]       fill_q, fill_d;
  logic [AW-1:0]    base_q, base_d, shad_q, shad_d;
  logic [BLK_W-1:0] blk_q, blk_d;

  assign wrap  = adv && (blk_q == LAST);
  assign armed = (fill_q == 2'd2);
  assign base  = base_q;
  assign blk   = blk_q;

  always_comb begin
    fill_d = fill_q;
    base_d = base_q;
    shad_d = shad_q;
    blk_d  = blk_q;
    if (ptr_wr) begin
      case (fill_q)
        2'd0:    begin base_d = ptr_wdata; fill_d = 2'd1; end
        2'd1:    begin shad_d = ptr_wdata; fill_d = 2'd2; end
        default: shad_d = ptr_wdata;
      endcase
    end
    if (adv) begin
      blk_d = wrap ? '0 : blk_q + 1'b1;
      if (wrap) base_d = shad_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      base_q <= '0;
      shad_q <= '0;
      blk_q  <= '0;
    end else begin
      fill_q <= fill_d;
      base_q <= base_d;
      shad_q <= shad_d;
      blk_q  <= blk_d;
    end
  end

  // R2: second pointer write goes to the shadow and arms the block
  p_second_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q == 2'd1 && ptr_wr) |=> (shad_q == $past(ptr_wdata)) && armed);
  // R3: live base is frozen between transfers
  p_base_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !wrap) |=> $stable(base_q));
  // R4: transfer copies the old shadow and restarts numbering
  p_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (base_q == $past(shad_q)) && (blk_q == '0));
endmodule

// File: rtl/pb_irq.sv
module pb_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic fl_q, fl_d;
    always_comb begin
      fl_d = fl_q;
      if (clr_wr && clr_mask[g]) fl_d = 1'b0;
      if (set[g]) fl_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fl_q <= 1'b0;
      else        fl_q <= fl_d;
    end
    assign flags[g] = fl_q;

    // R9: a flag stays set until the host clears it
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_q && !(clr_wr && clr_mask[g])) |=> fl_q);
    // R9: a set event is always visible one cycle later
    p_set_seen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set[g] |=> fl_q);
  end
endmodule

// File: rtl/pb_pkt_writer.sv
module pb_pkt_writer
  import pktbuf_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BLK_W     = 4,
  parameter int BLK_WORDS = 512,
  parameter int HDR_WORDS = 8,
  localparam int WA        = AW - 2,
  localparam int PAY_WORDS = BLK_WORDS - HDR_WORDS,
  localparam int CAP_BYTES = PAY_WORDS * 4,
  localparam int IW        = $clog2(PAY_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    base,
  input  logic [BLK_W-1:0] blk,
  input  logic             armed,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  input  logic             in_last,
  input  logic [LEN_W-1:0] in_len,
  input  logic [2:0]       in_port,
  input  logic [2:0]       in_ease,
  input  logic             in_sniff,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [WA-1:0]    mem_waddr,
  output logic [31:0]      mem_wdata,
  output logic             done,
  output logic             drop
);
  wr_state_e      st_q, st_d;
  logic           mv_q, mv_d, inpkt_q, inpkt_d, skip_q, skip_d;
  logic [WA-1:0]  addr_q, addr_d, blk_word;
  logic [31:0]    data_q, data_d;
  logic [IW-1:0]  widx_q, widx_d;
  pkt_desc_t      desc_q, desc_d;
  logic           slot_free, beat, skip_now, wr_now;

  assign blk_word  = base[AW-1:2] + WA'(blk) * WA'(BLK_WORDS);
  assign slot_free = !mv_q || mem_ready;
  assign in_ready  = (st_q == WS_DATA) && slot_free;
  assign beat      = in_valid && in_ready;
  assign skip_now  = inpkt_q ? skip_q : !armed;
  assign wr_now    = beat && !skip_now && (widx_q < IW'(PAY_WORDS));

  always_comb begin
    st_d    = st_q;
    mv_d    = mv_q && !mem_ready;
    addr_d  = addr_q;
    data_d  = data_q;
    widx_d  = widx_q;
    inpkt_d = inpkt_q;
    skip_d  = skip_q;
    desc_d  = desc_q;
    done    = 1'b0;
    drop    = 1'b0;
    case (st_q)
      WS_DATA: if (beat) begin
        inpkt_d = !in_last;
        skip_d  = skip_now;
        if (wr_now) begin
          mv_d   = 1'b1;
          addr_d = blk_word + WA'(HDR_WORDS) + WA'(widx_q);
          data_d = in_data;
          widx_d = widx_q + 1'b1;
        end
        if (in_last) begin
          desc_d.sniff = in_sniff;
          desc_d.ease  = in_ease;
          desc_d.port  = in_port;
          desc_d.cnt   = (in_len > LEN_W'(CAP_BYTES)) ? LEN_W'(CAP_BYTES) : in_len;
          if (skip_now) begin
            drop   = 1'b1;
            widx_d = '0;
          end else begin
            st_d = WS_STAT;
          end
        end
      end
      WS_STAT: if (slot_free) begin
        mv_d   = 1'b1;
        addr_d = blk_word;
        data_d = stat_word(desc_q);
        st_d   = WS_WAIT;
      end
      default: if (mem_ready) begin
        done   = 1'b1;
        widx_d = '0;
        st_d   = WS_DATA;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WS_DATA;
      mv_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      widx_q  <= '0;
      inpkt_q <= 1'b0;
      skip_q  <= 1'b0;
      desc_q  <= '0;
    end else begin
      st_q    <= st_d;
      mv_q    <= mv_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      widx_q  <= widx_d;
      inpkt_q <= inpkt_d;
      skip_q  <= skip_d;
      desc_q  <= desc_d;
    end
  end

  assign mem_valid = mv_q;
  assign mem_waddr = addr_q;
  assign mem_wdata = data_q;

  // R11: request is held until accepted
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_q && !mem_ready) |=> mv_q && $stable(addr_q) && $stable(data_q));
  // R7: payload never lands in the header area
  p_hdr_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_q && st_q != WS_WAIT) |-> ((addr_q - blk_word) >= WA'(HDR_WORDS)) &&
                                  ((addr_q - blk_word) < WA'(BLK_WORDS)));
  // R5: the completion write targets word 0 with the valid bit set
  p_status_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_WAIT && mv_q) |-> (addr_q == blk_word) && data_q[0]);
  // R10: a dropped packet loads no memory request
  p_drop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_DATA && inpkt_q && skip_q && !mv_q) |=> !mv_q);
endmodule

// File: rtl/pktbuf_mgr.sv
module pktbuf_mgr
  import pktbuf_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BLK_CNT   = 16,
  parameter int BLK_BYTES = 2048,
  parameter int HDR_WORDS = 8,
  localparam int BLK_W     = $clog2(BLK_CNT),
  localparam int BLK_WORDS = BLK_BYTES / 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_sel,
  input  logic [31:0]      host_wdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  input  logic             in_last,
  input  logic [10:0]      in_len,
  input  logic [2:0]       in_port,
  input  logic [2:0]       in_ease,
  input  logic             in_sniff,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [AW-3:0]    mem_waddr,
  output logic [31:0]      mem_wdata,
  output logic             irq_pkt,
  output logic             irq_wrap,
  output logic             irq_ovr
);
  logic [AW-1:0]    base;
  logic [BLK_W-1:0] blk;
  logic             armed, wrap, done, drop;
  logic [2:0]       flags;

  pb_ptr_regs #(.AW(AW), .BLK_CNT(BLK_CNT)) ptr_i (
    .clk(clk), .rst_n(rst_n),
    .ptr_wr(host_wr && !host_sel), .ptr_wdata(AW'(host_wdata)),
    .adv(done), .base(base), .blk(blk), .armed(armed), .wrap(wrap)
  );

  pb_pkt_writer #(.AW(AW), .BLK_W(BLK_W), .BLK_WORDS(BLK_WORDS),
                  .HDR_WORDS(HDR_WORDS)) wr_i (
    .clk(clk), .rst_n(rst_n),
    .base(base), .blk(blk), .armed(armed),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_len(in_len), .in_port(in_port),
    .in_ease(in_ease), .in_sniff(in_sniff),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .done(done), .drop(drop)
  );

  pb_irq #(.N(3)) irq_i (
    .clk(clk), .rst_n(rst_n),
    .set({drop, wrap, done}),
    .clr_wr(host_wr && host_sel), .clr_mask(host_wdata[2:0]),
    .flags(flags)
  );

  assign irq_pkt  = flags[0];
  assign irq_wrap = flags[1];
  assign irq_ovr  = flags[2];
endmodule

// File: tb/pktbuf_mgr_tb_top.sv
module pktbuf_mgr_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        host_wr = 0, host_sel = 0;
  logic [31:0] host_wdata = '0;
  logic        in_valid = 0, in_last = 0, in_sniff = 0;
  logic [31:0] in_data = '0;
  logic [10:0] in_len = '0;
  logic [2:0]  in_port = '0, in_ease = '0;
  logic        in_ready, mem_valid, irq_pkt, irq_wrap, irq_ovr;
  logic        mem_ready = 1'b0;
  logic [29:0] mem_waddr;
  logic [31:0] mem_wdata;

  int n_chk = 0, n_bad = 0, rmode = 1, cyc = 0, ln = 0, hdr_viol = 0;
  logic [29:0] la [0:1023];
  logic [31:0] ld [0:1023];

  localparam logic [31:0] A = 32'h0001_0000, B = 32'h0002_0000, C = 32'h0004_0000,
                          D = 32'h0006_0000, E = 32'h0008_0000;

  pktbuf_mgr dut_i (.*);

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // memory side: ready pattern, write log, header-area watch (R7)
  initial forever begin
    @(negedge clk);
    case (rmode)
      0:       mem_ready = 1'b1;
      1:       mem_ready = (cyc % 3) != 1;
      3:       mem_ready = (mem_waddr[8:0] != 9'd0);
      default: mem_ready = 1'b0;
    endcase
    #1;
    if (mem_valid && mem_ready) begin
      if (mem_waddr[8:0] >= 9'd1 && mem_waddr[8:0] <= 9'd7) hdr_viol++;
      if (ln < 1024) begin la[ln] = mem_waddr; ld[ln] = mem_wdata; ln++; end
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic hwr(bit sel, logic [31:0] d);
    @(negedge clk); host_wr = 1; host_sel = sel; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  function automatic int len_of(int id);
    case (id)
      3: return 2047; 5: return 2016; 6: return 2020; 20: return 2017;
      default: return 1 + (id * 37) % 61;
    endcase
  endfunction

  task automatic send(int id);
    int len = len_of(id);
    int beats = (len + 3) / 4;
    ln = 0;
    for (int i = 0; i < beats; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = id * 65536 + i; in_last = (i == beats - 1);
      in_len = 11'(len); in_port = 3'(id % 8); in_ease = 3'((id * 5 + 1) % 8);
      in_sniff = (id % 3) == 0;
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      #1 in_valid = 0; in_last = 0;
    end
  endtask

  task automatic wait_flag(int which, output bit seen);
    seen = 0;
    for (int t = 0; t < 4000 && !seen; t++) begin
      @(negedge clk); #1;
      seen = (which == 0) ? irq_pkt : irq_ovr;
    end
  endtask

  // checks one completed packet against the requirement arithmetic
  task automatic verify(int id, logic [31:0] rbase, int k, string areq);
    bit seen;
    int len = len_of(id);
    int nw = (len + 3) / 4;
    int cnt = (len > 2016) ? 2016 : len;
    int bad = 0;
    longint sw;
    logic [29:0] bw = 30'(rbase >> 2) + 30'(k * 512);
    wait_flag(0, seen);
    chk(seen, "R9", "irq_pkt after packet", irq_pkt, 1);
    if (nw > 504) nw = 504;
    chk(ln == nw + 1, (len > 2016) ? "R8" : "R6", "write count", ln, nw + 1);
    for (int j = 0; j < nw && j < ln; j++)
      if (la[j] != bw + 30'(8 + j) || ld[j] != 32'(id * 65536 + j)) bad++;
    chk(bad == 0, areq, "payload address/data mismatches", bad, 0);
    sw = ((id % 3 == 0) ? 64'h8000_0000 : 0) | (longint'((id * 5 + 1) % 8) << 15) |
         (longint'(id % 8) << 12) | (longint'(cnt) << 1) | 1;
    chk(ln > 0 && la[ln-1] == bw, "R6", "last write is status at word 0", la[ln-1], bw);
    chk(ln > 0 && ld[ln-1] == 32'(sw), (len > 2016) ? "R8" : "R5", "status word", ld[ln-1], sw);
    chk(irq_wrap == (k == 15), "R9", "irq_wrap level", irq_wrap, k == 15);
    hwr(1, 32'h3);
    #1 chk(!irq_pkt && !irq_wrap, "R9", "flags after clear", {irq_wrap, irq_pkt}, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
  end

  initial begin
    bit seen;
    int id = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk({irq_pkt, irq_wrap, irq_ovr} == 0, "R9", "flags after reset", {irq_pkt, irq_wrap, irq_ovr}, 0);
    chk(!mem_valid, "R11", "no request after reset", mem_valid, 0);

    // R10: packet before both pointers are loaded
    send(100);
    wait_flag(2, seen);
    chk(seen, "R10", "overrun flag", irq_ovr, 1);
    chk(ln == 0, "R10", "writes for dropped packet", ln, 0);
    chk(!irq_pkt, "R10", "no packet flag for drop", irq_pkt, 0);
    hwr(1, 32'h4);
    #1 chk(!irq_ovr, "R9", "overrun cleared", irq_ovr, 0);

    hwr(0, A); hwr(0, B); hwr(0, C);   // R2: base, shadow, shadow again

    rmode = 1;                          // region 1 at A, stalling memory
    for (int k = 0; k < 16; k++) begin send(id); verify(id, A, k, "R1 R2"); id++; end

    for (int k = 0; k < 15; k++) begin  // region 2 at C; R3 mid-region shadow write
      if (k == 4) hwr(0, D);
      send(id); verify(id, C, k, (k > 4) ? "R3" : "R2"); id++;
    end

    // R4: last packet of region 2, pointer write on the transfer edge
    rmode = 3;
    send(id);
    seen = 0;
    for (int t = 0; t < 4000 && !seen; t++) begin
      @(negedge clk); #1; seen = mem_valid && (mem_waddr[8:0] == 9'd0);
    end
    chk(seen, "R6", "status pending under stall", seen, 1);
    @(posedge clk); #1 host_wr = 1; host_sel = 0; host_wdata = E; rmode = 0;
    @(posedge clk); #1 host_wr = 0;
    verify(id, C, 15, "R1"); id++;

    for (int k = 0; k < 16; k++) begin send(id); verify(id, D, k, "R4"); id++; end
    send(id); verify(id, E, 0, "R4"); id++;

    chk(hdr_viol == 0, "R7", "writes into words 1..7", hdr_viol, 0);
    summary();
  end
endmodule